// File: doc/BRIEF.md
# Instruction Fetch and Operand Sequencer

This block is the front end of a small 16-bit processor in which register 0 serves as the program counter. Each step takes one word from a read-only program memory and splits it into five fields. Bits 3:0 hold the source selector, bits 5:4 the addressing mode, bits 7:6 the operation class, bits 11:8 the modifier, and bits 15:12 the destination. From these it forms the source operand and hands a decoded bundle to the execution unit. The bundle holds the operation, modifier, destination index, source operand and the old destination value. The block then moves the program counter on.

The memory mode reads the operand from program memory. It takes a second memory cycle, and during that cycle the operation, modifier and destination come from a 10-bit holding register rather than from the memory word. Jumps are resolved inside the block, and a jump can write a return address to a general register. When any other operation targets register 0, the block waits until the execution unit returns the new program counter. Registers 1 and up live outside the block and are read through a flat bus. Indices at or above the implemented register count read as zero.

Top module: `ifetch_seq`

## Requirements
- R1: After synchronous reset, `pc` and `rom_addr` are 0 and `iss_valid` and `link_we` are 0.
- R2: Mode 0 (bits 5:4 = 00) issues the 4-bit selector as a constant, with its bit 3 copied into every higher bit.
- R3: Mode 1 (bits 5:4 = 01) issues the destination register's value plus the selector, zero-extended. Register 0 reads as the address of the current instruction.
- R4: Mode 2 (bits 5:4 = 10) issues the value of the register named by the selector. Register 0 reads as the address of the current instruction.
- R5: A register index at or above NREGS reads as zero, both as a source and as the issued destination value.
- R6: Mode 3 (bits 5:4 = 11) with a nonzero selector issues nothing in its first step. The next step fetches from the address held in the selected register and issues that word as the source. The operation, modifier and destination come from the first word, and the program counter advances by 1.
- R7: Mode 3 with selector 0 fetches the word at `pc`+1 as the source, and the program counter advances by 2.
- R8: An issued bundle carries operation = bits 7:6, modifier = bits 11:8, destination = bits 15:12, and `iss_dval` = the destination register's value. A non-jump with a nonzero destination moves `pc` and `rom_addr` to the next instruction.
- R9: A jump is operation 01 with modifier 1111. It loads the source into `pc` and `rom_addr`. If the destination is nonzero, it also pulses `link_we` with `link_dst` = destination and `link_val` = the address after the instruction (one or two words).
- R10: A non-jump with destination 0 freezes fetching until `pc_wr_en`. Then `pc` and `rom_addr` take `pc_wr_data`. `pc_wr_en` has no effect at any other time.
- R11: While `run` is low, `pc`, `rom_addr` and the extra-cycle state hold, and `iss_valid` and `link_we` stay low.
- R12: The extra-cycle state lasts exactly one executed step. The word fetched after an inline operand is decoded as an instruction, even if it has mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Step enable |
| rom_data | input | W | Program memory word at `rom_addr` |
| rom_addr | output | W | Program memory address, registered |
| gpr_rd | input | (NREGS-1)*W | Registers 1..NREGS-1, register r at bits (r-1)*W |
| pc_wr_en | input | 1 | Execution unit delivers a new program counter |
| pc_wr_data | input | W | New program counter value |
| pc | output | W | Register 0 |
| iss_valid | output | 1 | One-cycle pulse: bundle issued |
| iss_op | output | 2 | Operation class |
| iss_mod | output | 4 | Modifier |
| iss_dst | output | 4 | Destination index |
| iss_src | output | W | Source operand |
| iss_dval | output | W | Old destination value |
| link_we | output | 1 | Return-address write pulse |
| link_dst | output | 4 | Register receiving the return address |
| link_val | output | W | Return address |

## Verification
The hardest case to reach is a stall in the middle of a two-word instruction: `run` drops after the first word has been latched and before its operand has been read. This has to be followed by an operand word that itself looks like a memory-mode instruction, to show the extra-cycle state was not kept too long. Directed program segments place such words on purpose and lower `run` for several cycles between the two halves. A later phase fills program memory with random words and toggles `run` and `pc_wr_en` at random. This lets jumps, waits on register-0 writes and two-word instructions overlap in orders no directed segment lists.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef struct packed {
    logic [3:0] dst;
    logic [3:0] mod;
    logic [1:0] op;
  } ctl_t;

  typedef enum logic [1:0] {
    AM_IMM = 2'b00,
    AM_REL = 2'b01,
    AM_REG = 2'b10,
    AM_MEM = 2'b11
  } amode_t;

  localparam logic [1:0] OP_ARITH = 2'b01;
  localparam logic [3:0] MOD_JUMP = 4'hF;
endpackage

// File: rtl/seq_field_sel.sv
module seq_field_sel
  import seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] word,
  input  logic         xtra,
  input  ctl_t         held,
  output ctl_t         ctl,
  output logic [3:0]   selr,
  output amode_t       amode
);
  ctl_t from_word;

  always_comb begin
    from_word.dst = word[15:12];
    from_word.mod = word[11:8];
    from_word.op  = word[7:6];
    ctl   = xtra ? held : from_word;
    selr  = word[3:0];
    amode = amode_t'(word[5:4]);
  end
endmodule

// File: rtl/seq_reg_read.sv
module seq_reg_read #(
  parameter int W     = 16,
  parameter int NREGS = 16
) (
  input  logic [3:0]             idx,
  input  logic [W-1:0]           pc,
  input  logic [(NREGS-1)*W-1:0] gpr,
  output logic [W-1:0]           val
);
  logic [W-1:0] term [NREGS];

  assign term[0] = (idx == 4'd0) ? pc : '0;

  for (genvar r = 1; r < NREGS; r++) begin : g_port
    assign term[r] = (idx == 4'(r)) ? gpr[(r-1)*W +: W] : '0;
  end

  always_comb begin
    val = '0;
    for (int r = 0; r < NREGS; r++) val = val | term[r];
  end
endmodule

// File: rtl/seq_operand.sv
module seq_operand
  import seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         xtra,
  input  amode_t       amode,
  input  logic [3:0]   selr,
  input  logic [W-1:0] word,
  input  logic [W-1:0] sel_val,
  input  logic [W-1:0] dst_val,
  output logic [W-1:0] operand
);
  localparam int EXT = W - 4;

  always_comb begin
    if (xtra) begin
      operand = word;
    end else begin
      unique case (amode)
        AM_IMM:  operand = {{EXT{selr[3]}}, selr};
        AM_REL:  operand = dst_val + {{EXT{1'b0}}, selr};
        AM_REG:  operand = sel_val;
        default: operand = word;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import seq_pkg::*;
#(
  parameter int W     = 16,
  parameter int NREGS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic [W-1:0]           rom_data,
  output logic [W-1:0]           rom_addr,
  input  logic [(NREGS-1)*W-1:0] gpr_rd,
  input  logic                   pc_wr_en,
  input  logic [W-1:0]           pc_wr_data,
  output logic [W-1:0]           pc,
  output logic                   iss_valid,
  output logic [1:0]             iss_op,
  output logic [3:0]             iss_mod,
  output logic [3:0]             iss_dst,
  output logic [W-1:0]           iss_src,
  output logic [W-1:0]           iss_dval,
  output logic                   link_we,
  output logic [3:0]             link_dst,
  output logic [W-1:0]           link_val
);
  logic [W-1:0] pc_q, addr_q;
  logic         xtra_q, two_q, wait_q;
  ctl_t         held_q;

  ctl_t         ctl;
  logic [3:0]   selr;
  amode_t       amode;
  logic [W-1:0] sel_val, dst_val, operand, pc_adv;
  logic         is_jump, start_xtra;

  seq_field_sel #(.W(W)) u_fields (
    .word(rom_data), .xtra(xtra_q), .held(held_q),
    .ctl(ctl), .selr(selr), .amode(amode)
  );

  seq_reg_read #(.W(W), .NREGS(NREGS)) u_rd_sel (
    .idx(selr), .pc(pc_q), .gpr(gpr_rd), .val(sel_val)
  );

  seq_reg_read #(.W(W), .NREGS(NREGS)) u_rd_dst (
    .idx(ctl.dst), .pc(pc_q), .gpr(gpr_rd), .val(dst_val)
  );

  seq_operand #(.W(W)) u_opnd (
    .xtra(xtra_q), .amode(amode), .selr(selr), .word(rom_data),
    .sel_val(sel_val), .dst_val(dst_val), .operand(operand)
  );

  always_comb begin
    pc_adv     = pc_q + ((xtra_q && two_q) ? W'(2) : W'(1));
    is_jump    = (ctl.op == OP_ARITH) && (ctl.mod == MOD_JUMP);
    start_xtra = !xtra_q && (amode == AM_MEM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      addr_q    <= '0;
      xtra_q    <= 1'b0;
      two_q     <= 1'b0;
      wait_q    <= 1'b0;
      held_q    <= '0;
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_mod   <= '0;
      iss_dst   <= '0;
      iss_src   <= '0;
      iss_dval  <= '0;
      link_we   <= 1'b0;
      link_dst  <= '0;
      link_val  <= '0;
    end else begin
      iss_valid <= 1'b0;
      link_we   <= 1'b0;
      if (run) begin
        if (wait_q) begin
          if (pc_wr_en) begin
            pc_q   <= pc_wr_data;
            addr_q <= pc_wr_data;
            wait_q <= 1'b0;
          end
        end else if (start_xtra) begin
          xtra_q <= 1'b1;
          held_q <= ctl;
          two_q  <= (selr == 4'd0);
          addr_q <= (selr == 4'd0) ? pc_q + W'(1) : sel_val;
        end else begin
          xtra_q    <= 1'b0;
          iss_valid <= 1'b1;
          iss_op    <= ctl.op;
          iss_mod   <= ctl.mod;
          iss_dst   <= ctl.dst;
          iss_src   <= operand;
          iss_dval  <= dst_val;
          if (is_jump) begin
            pc_q   <= operand;
            addr_q <= operand;
            if (ctl.dst != 4'd0) begin
              link_we  <= 1'b1;
              link_dst <= ctl.dst;
              link_val <= pc_adv;
            end
          end else if (ctl.dst == 4'd0) begin
            wait_q <= 1'b1;
          end else begin
            pc_q   <= pc_adv;
            addr_q <= pc_adv;
          end
        end
      end
    end
  end

  assign pc       = pc_q;
  assign rom_addr = addr_q;
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic [5:0]   word_lo,
  input logic [W-1:0] pc,
  input logic [W-1:0] rom_addr,
  input logic         iss_valid,
  input logic [W-1:0] iss_src,
  input logic         link_we,
  input logic [3:0]   link_dst,
  input logic         pc_wr_en,
  input logic         xtra_q,
  input logic         wait_q
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && rom_addr == '0 && !iss_valid && !link_we));

  p_imm_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !xtra_q && !wait_q && word_lo[5:4] == 2'b00) |=>
    (iss_valid && iss_src == {{(W-4){$past(word_lo[3])}}, $past(word_lo[3:0])}));

  p_mem_first_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !xtra_q && !wait_q && word_lo[5:4] == 2'b11) |=> (!iss_valid && xtra_q));

  p_link_has_issue_r9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (iss_valid && link_dst != 4'd0));

  p_wait_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !pc_wr_en) |=> ($stable(pc) && !iss_valid));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pc) && $stable(rom_addr) && $stable(xtra_q) && !iss_valid && !link_we));

  p_extra_once_r12: assert property (@(posedge clk) disable iff (rst)
    (xtra_q && run) |=> !xtra_q);
endmodule

bind ifetch_seq ifetch_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .word_lo(rom_data[5:0]),
  .pc(pc), .rom_addr(rom_addr), .iss_valid(iss_valid), .iss_src(iss_src),
  .link_we(link_we), .link_dst(link_dst), .pc_wr_en(pc_wr_en),
  .xtra_q(xtra_q), .wait_q(wait_q)
);

// File: tb/sim_ifetch_seq.sv
module sim_ifetch_seq;
  localparam int NR = 12;

  logic clk = 1'b0;
  logic rst, run, pc_wr_en;
  logic [15:0] pc_wr_data;
  logic [15:0] rom_addr, rom_data, pc, iss_src, iss_dval, link_val;
  logic [(NR-1)*16-1:0] gpr_bus;
  logic iss_valid, link_we;
  logic [1:0] iss_op;
  logic [3:0] iss_mod, iss_dst, link_dst;

  logic [15:0] rom [0:255];
  logic [15:0] g [0:15];

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // model state
  logic [15:0] m_pc, m_addr;
  logic m_x, m_two, m_wait;
  logic [3:0] m_ld, m_lm;
  logic [1:0] m_lo;
  logic e_iv, e_lw;
  logic [1:0] e_op;
  logic [3:0] e_mod, e_dst, e_ldst;
  logic [15:0] e_src, e_dval, e_lval;

  always #4 clk = ~clk;

  assign rom_data = rom[rom_addr[7:0]];

  always_comb begin
    gpr_bus = '0;
    for (int r = 1; r < NR; r++) gpr_bus[(r-1)*16 +: 16] = g[r];
  end

  ifetch_seq #(.W(16), .NREGS(NR)) u0 (
    .clk(clk), .rst(rst), .run(run), .rom_data(rom_data), .rom_addr(rom_addr),
    .gpr_rd(gpr_bus), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc(pc),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_mod(iss_mod), .iss_dst(iss_dst),
    .iss_src(iss_src), .iss_dval(iss_dval), .link_we(link_we),
    .link_dst(link_dst), .link_val(link_val)
  );

  function automatic logic [15:0] enc(input logic [3:0] d, input logic [3:0] mo,
                                      input logic [1:0] o, input logic [1:0] a,
                                      input logic [3:0] s);
    return {d, mo, o, a, s};
  endfunction

  function automatic logic [15:0] mrv(input logic [3:0] i);
    if (i == 4'd0) return m_pc;
    if (int'(i) >= NR) return 16'h0000;
    return g[i];
  endfunction

  task automatic check(input string t, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    check(tag, "pc", pc, m_pc);
    check(tag, "rom_addr", rom_addr, m_addr);
    check(tag, "iss_valid", 16'(iss_valid), 16'(e_iv));
    check(tag, "link_we", 16'(link_we), 16'(e_lw));
    if (e_iv) begin
      check("R8", "iss_op", 16'(iss_op), 16'(e_op));
      check("R8", "iss_mod", 16'(iss_mod), 16'(e_mod));
      check("R8", "iss_dst", 16'(iss_dst), 16'(e_dst));
      check("R8", "iss_dval", iss_dval, e_dval);
      check(tag, "iss_src", iss_src, e_src);
    end
    if (e_lw) begin
      check("R9", "link_dst", 16'(link_dst), 16'(e_ldst));
      check("R9", "link_val", link_val, e_lval);
    end
  endtask

  task automatic model_step();
    logic [15:0] w, s, adv;
    logic [3:0] d, mo;
    logic [1:0] o;
    e_iv = 1'b0;
    e_lw = 1'b0;
    if (run) begin
      if (m_wait) begin
        if (pc_wr_en) begin
          m_pc = pc_wr_data;
          m_addr = pc_wr_data;
          m_wait = 1'b0;
        end
      end else begin
        w = rom[m_addr[7:0]];
        if (!m_x && w[5:4] == 2'b11) begin
          m_x = 1'b1;
          m_ld = w[15:12];
          m_lm = w[11:8];
          m_lo = w[7:6];
          m_two = (w[3:0] == 4'd0);
          m_addr = m_two ? m_pc + 16'd1 : mrv(w[3:0]);
        end else begin
          if (m_x) begin
            d = m_ld; mo = m_lm; o = m_lo; s = w;
            adv = m_two ? 16'd2 : 16'd1;
          end else begin
            d = w[15:12]; mo = w[11:8]; o = w[7:6]; adv = 16'd1;
            case (w[5:4])
              2'b00:   s = {{12{w[3]}}, w[3:0]};
              2'b01:   s = mrv(w[15:12]) + {12'h000, w[3:0]};
              default: s = mrv(w[3:0]);
            endcase
          end
          m_x = 1'b0;
          e_iv = 1'b1;
          e_op = o; e_mod = mo; e_dst = d; e_src = s; e_dval = mrv(d);
          if (o == 2'b01 && mo == 4'hF) begin
            if (d != 4'd0) begin
              e_lw = 1'b1;
              e_ldst = d;
              e_lval = m_pc + adv;
            end
            m_pc = s;
            m_addr = s;
          end else if (d == 4'd0) begin
            m_wait = 1'b1;
          end else begin
            m_pc = m_pc + adv;
            m_addr = m_pc;
          end
        end
      end
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    for (int r = 0; r < 16; r++) g[r] = 16'h0100 * 16'(r) + 16'(r);
    g[10] = 16'h0020;
    // directed program
    rom[0]    = enc(1, 8, 1, 0, 4'hA);
    rom[1]    = enc(2, 0, 0, 0, 4'h5);
    rom[2]    = enc(3, 8, 1, 1, 4'h7);
    rom[3]    = enc(5, 0, 0, 2, 4'h4);
    rom[4]    = enc(6, 0, 0, 2, 4'h0);
    rom[5]    = enc(13, 0, 0, 2, 4'h2);
    rom[6]    = enc(4, 0, 0, 2, 4'hE);
    rom[7]    = enc(7, 8, 1, 3, 4'h3);
    rom[8]    = enc(8, 10, 1, 3, 4'h0);
    rom[9]    = 16'hC0B0;
    rom[10]   = enc(9, 15, 1, 2, 4'hA);
    rom[8'h20] = enc(0, 15, 1, 3, 4'h0);
    rom[8'h21] = 16'h0030;
    rom[8'h30] = enc(11, 15, 1, 3, 4'h0);
    rom[8'h31] = 16'h0040;
    rom[8'h40] = enc(0, 8, 1, 0, 4'h1);
    rom[8'h50] = enc(1, 0, 0, 0, 4'h3);
    rom[8'h51] = enc(2, 0, 0, 3, 4'h0);
    rom[8'h52] = 16'h00F3;
    rom[8'h53] = enc(3, 0, 0, 0, 4'h9);

    rst = 1'b1; run = 1'b0; pc_wr_en = 1'b0; pc_wr_data = 16'h0000;
    m_pc = '0; m_addr = '0; m_x = 1'b0; m_two = 1'b0; m_wait = 1'b0;
    m_ld = '0; m_lm = '0; m_lo = '0; e_iv = 1'b0; e_lw = 1'b0;
    e_op = '0; e_mod = '0; e_dst = '0; e_ldst = '0;
    e_src = '0; e_dval = '0; e_lval = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    compare();

    run = 1'b1;
    tag = "R2"; tick(2);
    tag = "R3"; pc_wr_en = 1'b1; pc_wr_data = 16'hDEAD; tick(1);   // R10: ignored here
    pc_wr_en = 1'b0;
    tag = "R4"; tick(2);
    tag = "R5"; tick(2);
    tag = "R6"; tick(2);
    tag = "R7"; tick(2);
    tag = "R12"; tick(1);
    tag = "R9"; tick(5);
    tag = "R10"; tick(4);
    pc_wr_en = 1'b1; pc_wr_data = 16'h0050; tick(1);
    pc_wr_en = 1'b0;
    tag = "R11"; run = 1'b0; tick(3);
    run = 1'b1; tick(2);
    run = 1'b0; tick(2);
    run = 1'b1; tick(1);
    tag = "R12"; tick(1);

    // random phase
    tag = "RND";
    for (int i = 0; i < 256; i++) rom[i] = 16'($urandom);
    for (int k = 0; k < 4000; k++) begin
      run = ($urandom_range(0, 9) != 0);
      pc_wr_en = ($urandom_range(0, 3) == 0);
      pc_wr_data = 16'($urandom);
      if ($urandom_range(0, 15) == 0) g[$urandom_range(1, 15)] = 16'($urandom);
      tick(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule